// File: doc/BRIEF.md
# Audio Transmitter Register Block with APB Access

This block is the bus-facing register file of an audio transmitter. A host talks to it through an APB completer port that follows the two-step setup/enable handshake. The block keeps the transmitter's control settings, exposes a status word built from the transmit FIFO's flags, turns writes to a dedicated data address into push strobes for that FIFO, and raises a level interrupt whenever an enabled status condition is present.

The FIFO and the serial audio shifter sit outside. They connect through a push strobe with its sample word, three flag inputs (full, empty, half-empty) and the control outputs: transmitter enable, justification mode and sample-rate code. A transfer takes effect only in an enable cycle that directly follows a setup cycle. Read data is captured at the end of the setup cycle and is held steady until the next read setup.

Top module: `audio_apb_regs`

## Requirements
- R1: After a synchronous reset, all stored registers are zero, and irq, push and prdata are low.
- R2: A write that completes at byte address 0x00, 0x04 or 0x0C stores pwdata bits [1:0], [2:0] or [RATE_W-1:0] into the control, mask or rate register. The control register drives tx_enable from bit 0 and justify_mode from bit 1, and the rate register drives rate_sel. A setup cycle that is not followed by an enable cycle changes nothing.
- R3: A read returns the addressed register zero-extended in prdata during the enable cycle. The status word at 0x08 has bit 0 = FIFO empty, bit 1 = FIFO half-empty and bit 2 = overflow. prdata changes only at the clock edge that ends a read setup cycle.
- R4: Reads of the data address 0x10, of unmapped addresses and of misaligned addresses return zero. Writes to unmapped addresses change no register.
- R5: A write to 0x10 while fifo_full is low raises push, with push_data equal to pwdata, for that enable cycle only.
- R6: A write to 0x10 while fifo_full is high produces no push and sets the overflow bit, which stays set until it is cleared.
- R7: Writing status at 0x08 with bit 2 set clears overflow. Writing it with bit 2 clear, or writing any other status bit, has no effect.
- R8: irq is registered and equals the OR over bits i of (status[i] AND mask[i]) as they stood in the previous cycle.
- R9: Back-to-back transfers, where an enable cycle is followed at once by the next setup cycle, are each carried out. An enable cycle that is not preceded by a setup cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Enable phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in enable cycle |
| fifo_full | input | 1 | Transmit FIFO full flag |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| fifo_half | input | 1 | Transmit FIFO half-empty flag |
| push | output | 1 | FIFO push strobe |
| push_data | output | DATA_W | Sample word pushed into the FIFO |
| tx_enable | output | 1 | Transmitter enable |
| justify_mode | output | 1 | Justification mode select |
| rate_sel | output | RATE_W | Sample-rate code |
| irq | output | 1 | Level interrupt |

## Verification
Two things can happen in the same cycle: a mask write completes, and the FIFO flags change. The bench changes fifo_empty and fifo_half in the exact enable cycle of a mask write. It then checks irq on the next two cycles. The first cycle must show the old mask combined with the new flags, and the second the new mask with the new flags. A second case pairs an overflowing data write with a mask that already enables overflow, so that the sticky set and the interrupt path follow one another in consecutive cycles.

// File: rtl/audio_apb_pkg.sv
package audio_apb_pkg;

  localparam int STAT_W = 3;
  localparam int CFG_W  = 2;

  localparam int ST_EMPTY = 0;
  localparam int ST_HALF  = 1;
  localparam int ST_OVF   = 2;

  localparam int OFS_CFG  = 'h00;
  localparam int OFS_MASK = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_RATE = 'h0C;
  localparam int OFS_DATA = 'h10;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ENABLE} bus_phase_e;

  typedef enum logic [2:0] {
    SEL_CFG, SEL_MASK, SEL_STAT, SEL_RATE, SEL_DATA, SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/apb_phase_track.sv
module apb_phase_track
  import audio_apb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic psel,
  input  logic penable,
  output logic setup_cyc,
  output logic access_cyc
);

  bus_phase_e phase_q, phase_d;

  assign setup_cyc  = psel & ~penable;
  assign access_cyc = psel & penable & (phase_q == PH_SETUP);

  always_comb begin
    if (setup_cyc)       phase_d = PH_SETUP;
    else if (access_cyc) phase_d = PH_ENABLE;
    else                 phase_d = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

endmodule

// File: rtl/audio_addr_decode.sv
module audio_addr_decode
  import audio_apb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_e          sel
);

  always_comb begin
    if      (paddr == ADDR_W'(OFS_CFG))  sel = SEL_CFG;
    else if (paddr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
    else if (paddr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (paddr == ADDR_W'(OFS_RATE)) sel = SEL_RATE;
    else if (paddr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
    else                                 sel = SEL_NONE;
  end

endmodule

// File: rtl/audio_reg_bank.sv
module audio_reg_bank
  import audio_apb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setup_cyc,
  input  logic              access_cyc,
  input  logic              pwrite,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              fifo_half,
  output logic [DATA_W-1:0] prdata,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [STAT_W-1:0] mask_q,
  output logic [RATE_W-1:0] rate_q,
  output logic [STAT_W-1:0] stat_w,
  output logic              push,
  output logic [DATA_W-1:0] push_data
);

  logic              ovf_q;
  logic              wr_acc;
  logic              data_wr;
  logic [DATA_W-1:0] rd_mux;

  assign wr_acc  = access_cyc & pwrite;
  assign data_wr = wr_acc & (sel == SEL_DATA);

  assign push      = data_wr & ~fifo_full;
  assign push_data = pwdata;

  always_comb begin
    stat_w           = '0;
    stat_w[ST_EMPTY] = fifo_empty;
    stat_w[ST_HALF]  = fifo_half;
    stat_w[ST_OVF]   = ovf_q;
  end

  always_comb begin
    unique case (sel)
      SEL_CFG:  rd_mux = DATA_W'(cfg_q);
      SEL_MASK: rd_mux = DATA_W'(mask_q);
      SEL_STAT: rd_mux = DATA_W'(stat_w);
      SEL_RATE: rd_mux = DATA_W'(rate_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      mask_q <= '0;
      rate_q <= '0;
    end else if (wr_acc) begin
      if (sel == SEL_CFG)  cfg_q  <= pwdata[CFG_W-1:0];
      if (sel == SEL_MASK) mask_q <= pwdata[STAT_W-1:0];
      if (sel == SEL_RATE) rate_q <= pwdata[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                         ovf_q <= 1'b0;
    else if (data_wr & fifo_full)                    ovf_q <= 1'b1;
    else if (wr_acc & (sel == SEL_STAT) & pwdata[ST_OVF]) ovf_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                       prdata <= '0;
    else if (setup_cyc & ~pwrite)  prdata <= rd_mux;
  end

endmodule

// File: rtl/audio_irq_combine.sv
module audio_irq_combine #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] mask,
  output logic         irq
);

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = stat[i] & mask[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hit;
  end

endmodule

// File: rtl/audio_apb_regs.sv
module audio_apb_regs
  import audio_apb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              fifo_half,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              tx_enable,
  output logic              justify_mode,
  output logic [RATE_W-1:0] rate_sel,
  output logic              irq
);

  logic              setup_cyc;
  logic              access_cyc;
  reg_sel_e          sel;
  logic [CFG_W-1:0]  cfg_q;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] stat_w;

  apb_phase_track u_phase (
    .clk        (clk),
    .rst        (rst),
    .psel       (psel),
    .penable    (penable),
    .setup_cyc  (setup_cyc),
    .access_cyc (access_cyc)
  );

  audio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .paddr (paddr),
    .sel   (sel)
  );

  audio_reg_bank #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .setup_cyc  (setup_cyc),
    .access_cyc (access_cyc),
    .pwrite     (pwrite),
    .sel        (sel),
    .pwdata     (pwdata),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_half  (fifo_half),
    .prdata     (prdata),
    .cfg_q      (cfg_q),
    .mask_q     (mask_q),
    .rate_q     (rate_sel),
    .stat_w     (stat_w),
    .push       (push),
    .push_data  (push_data)
  );

  audio_irq_combine #(.N(STAT_W)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .stat (stat_w),
    .mask (mask_q),
    .irq  (irq)
  );

  assign tx_enable    = cfg_q[0];
  assign justify_mode = cfg_q[1];

endmodule

// File: rtl/audio_apb_regs_chk.sv
module audio_apb_regs_chk
  import audio_apb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              fifo_full,
  input logic              push,
  input logic              irq,
  input logic [STAT_W-1:0] stat_w,
  input logic [STAT_W-1:0] mask_q
);

  logic stat_clr_wr;
  assign stat_clr_wr = psel && penable && pwrite &&
                       (paddr == ADDR_W'(OFS_STAT)) && pwdata[ST_OVF];

  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
    push |-> (psel && penable && pwrite && !fifo_full)); // R5

  AST_PUSH_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(psel && !penable)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_w[ST_OVF] && !stat_clr_wr) |=> stat_w[ST_OVF]); // R6

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_clr_wr && $past(psel && !penable)) |=> !stat_w[ST_OVF]); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(stat_w & mask_q)))); // R8

  AST_PRDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(psel && !penable && !pwrite) |=> $stable(prdata)); // R3

endmodule

bind audio_apb_regs audio_apb_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .fifo_full (fifo_full),
  .push      (push),
  .irq       (irq),
  .stat_w    (stat_w),
  .mask_q    (mask_q)
);

// File: tb/audio_apb_regs_tb.sv
module audio_apb_regs_tb;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int RATE_W = 4;

  localparam logic [ADDR_W-1:0] A_CFG  = 12'h000;
  localparam logic [ADDR_W-1:0] A_MASK = 12'h004;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h008;
  localparam logic [ADDR_W-1:0] A_RATE = 12'h00C;
  localparam logic [ADDR_W-1:0] A_DATA = 12'h010;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic              fifo_full = 1'b0, fifo_empty = 1'b0, fifo_half = 1'b0;
  logic              push;
  logic [DATA_W-1:0] push_data;
  logic              tx_enable, justify_mode, irq;
  logic [RATE_W-1:0] rate_sel;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [1:0]        m_cfg  = '0;
  logic [2:0]        m_mask = '0;
  logic [RATE_W-1:0] m_rate = '0;
  logic              m_ovf  = 1'b0;

  always #5 clk = ~clk;

  audio_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATE_W(RATE_W)) u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
    .push(push), .push_data(push_data), .tx_enable(tx_enable),
    .justify_mode(justify_mode), .rate_sel(rate_sel), .irq(irq)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat();
    return {m_ovf, fifo_half, fifo_empty};
  endfunction

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    case (a)
      A_CFG:   return DATA_W'(m_cfg);
      A_MASK:  return DATA_W'(m_mask);
      A_STAT:  return DATA_W'(exp_stat());
      A_RATE:  return DATA_W'(m_rate);
      default: return '0;
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    if (a == A_DATA) begin
      check("R5/R6 push", DATA_W'(push), DATA_W'(!fifo_full));
      if (!fifo_full) check("R5 push_data", push_data, d);
      else            m_ovf = 1'b1;
    end else begin
      check("R5 no push", DATA_W'(push), '0);
    end
    case (a)
      A_CFG:  m_cfg  = d[1:0];
      A_MASK: m_mask = d[2:0];
      A_RATE: m_rate = d[RATE_W-1:0];
      A_STAT: if (d[2]) m_ovf = 1'b0;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    check(req, prdata, exp_read(a));
  endtask

  task automatic check_outputs(input string req);
    check({req, " tx_enable"},    DATA_W'(tx_enable), DATA_W'(m_cfg[0]));
    check({req, " justify_mode"}, DATA_W'(justify_mode), DATA_W'(m_cfg[1]));
    check({req, " rate_sel"},     DATA_W'(rate_sel), DATA_W'(m_rate));
    check("R8 irq", DATA_W'(irq), DATA_W'(|(exp_stat() & m_mask)));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_A0D1));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    check("R1 prdata", prdata, '0);
    check("R1 push", DATA_W'(push), '0);
    check_outputs("R1");
    bus_read(A_CFG, "R1 cfg read");
    bus_read(A_MASK, "R1 mask read");
    bus_read(A_RATE, "R1 rate read");

    // R2: register writes, back-to-back (R9)
    bus_write(A_CFG, 32'hFFFF_FFFD);
    bus_write(A_RATE, 32'h0000_0007);
    bus_write(A_MASK, 32'h0000_0006);
    bus_read(A_CFG, "R9 back-to-back read cfg");
    bus_read(A_RATE, "R2 read rate");
    idle(1);
    check_outputs("R2");

    // R2: setup without enable changes nothing
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = A_CFG; pwdata = 32'h2;
    idle(2);
    check_outputs("R2 setup-only");

    // R9: enable without setup is ignored
    fifo_full = 1'b0;
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = A_DATA; pwdata = 32'hDEAD_BEEF;
    #1;
    check("R9 stray enable push", DATA_W'(push), '0);
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = A_RATE; pwdata = 32'h3;
    idle(2);
    check("R9 stray enable rate", DATA_W'(rate_sel), DATA_W'(m_rate));

    // R4: unmapped, misaligned and data-port reads; unmapped write
    bus_write(12'h014, 32'hFFFF_FFFF);
    bus_write(12'h001, 32'hFFFF_FFFF);
    bus_read(12'h014, "R4 unmapped read");
    bus_read(12'h009, "R4 misaligned read");
    bus_read(A_DATA, "R4 data read");
    bus_read(A_CFG, "R4 cfg kept");
    bus_read(A_MASK, "R4 mask kept");

    // R5: push with room
    bus_write(A_DATA, 32'h1234_5678);
    idle(1);
    check("R5 strobe one cycle", DATA_W'(push), '0);

    // R6 with R8: overflow while overflow is unmasked
    bus_write(A_MASK, 32'h4);
    idle(2);
    check("R8 irq quiet", DATA_W'(irq), '0);
    fifo_full = 1'b1;
    bus_write(A_DATA, 32'hCAFE_0001);
    idle(1);
    check("R8 irq not yet", DATA_W'(irq), '0);
    idle(1);
    check("R6 irq from overflow", DATA_W'(irq), 32'h1);
    fifo_full = 1'b0;
    bus_read(A_STAT, "R6 overflow sticky");

    // R7: writes that must not clear, then a clearing write
    bus_write(A_STAT, 32'h3);
    bus_read(A_STAT, "R7 bit2 clear keeps overflow");
    bus_write(A_STAT, 32'h4);
    bus_read(A_STAT, "R7 overflow cleared");
    idle(2);
    check("R7 irq drops", DATA_W'(irq), '0);

    // Coincidence: mask write completes while FIFO flags change
    bus_write(A_MASK, 32'h1);
    fifo_empty = 1'b0; fifo_half = 1'b0;
    idle(2);
    check("R8 irq base", DATA_W'(irq), '0);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = A_MASK; pwdata = 32'h2;
    @(negedge clk);
    penable = 1'b1;
    fifo_empty = 1'b1; fifo_half = 1'b0;
    m_mask = 3'h2;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    check("R8 old mask new flags", DATA_W'(irq), 32'h1);
    @(negedge clk);
    check("R8 new mask new flags", DATA_W'(irq), 32'h0);

    // Random mix
    for (int i = 0; i < 80; i++) begin
      int op;
      @(negedge clk);
      fifo_full  = ($urandom % 3) == 0;
      fifo_empty = $urandom % 2;
      fifo_half  = $urandom % 2;
      op = $urandom % 7;
      case (op)
        0: bus_write(A_CFG,  $urandom);
        1: bus_write(A_MASK, $urandom);
        2: bus_write(A_RATE, $urandom);
        3: bus_write(A_STAT, $urandom);
        4: bus_write(A_DATA, $urandom);
        5: bus_read(A_STAT, "R3 random status read");
        default: bus_read(12'(($urandom % 6) * 4), "R3 random read");
      endcase
      idle(2);
      check_outputs("R2 random");
    end

    done = 1;
    finish_run();
  end

endmodule